// File: doc/BRIEF.md
# Single-Wire Bus ROM Command and Search Layer

This block is the device-selection layer of a slave on a multidrop single-wire bus. The bit-level front end handles the analog slot timing. It passes this layer one strobe for each written bit and one strobe for each read slot the master opens. After every bus reset and presence sequence, the layer collects an 8-bit ROM command, least significant bit first. It then carries out that command against the device's 64-bit identity. The identity holds an 8-bit family code in the low byte, a 48-bit serial number in the middle and an 8-bit CRC in the top byte.

Depending on the command, the layer returns the identity, compares it against an address the master writes, or takes part in the bit-by-bit search arbitration. The search uses wired-AND resolution: each bit is sent true, then sent complemented, then the master writes the chosen direction. The command ends in one of two ways. Either the layer raises `sel`, which hands the bit stream to the memory command layer, or it falls quiet until the next bus reset. Separately, a serial checker recomputes the CRC of the identity after power-up and on request.

Top module: `rom_select_layer`

## Requirements
- R1: After `rst` the layer is quiet: `sel` is 0 and every read slot is acknowledged with `rd_bit`=1 (line released) until `line_reset` is pulsed.
- R2: After `line_reset`, the first 8 write strobes form the command, least significant bit first. Any code other than 0x33, 0x55, 0xCC or 0xF0 leaves `sel` at 0, and later read slots return 1 until the next `line_reset`.
- R3: Command 0xCC raises `sel` right after its 8th bit, with no address phase.
- R4: Command 0x33 makes the next 64 read slots return `id_word` bit 0 up to bit 63 in that order. `sel` rises after the 64th slot.
- R5: Command 0x55 compares the next 64 written bits with `id_word` bit 0 up to bit 63. If all are equal, `sel` rises. On any mismatch the layer goes quiet: `sel` stays 0 and reads return 1.
- R6: Command 0xF0 runs 64 rounds. Each round is a read returning `id_word[i]`, then a read returning its inverse, then a write of the master's chosen bit. When all 64 chosen bits equal the identity, `sel` rises.
- R7: During 0xF0, a chosen bit that differs from `id_word[i]` makes the layer quiet: later reads return 1 and `sel` stays 0.
- R8: `line_reset` takes priority over any strobe in the same cycle. It returns the layer to command collection, and `sel` is 0 on the next cycle.
- R9: The CRC check shifts all 64 identity bits, LSB first, through an 8-bit register that starts at zero. It uses the polynomial x^8+x^5+x^4+1, reflected constant 0x8C. A zero remainder gives a one-cycle `crc_ok`, otherwise a one-cycle `crc_bad`. A check runs once after `rst` and again on each `crc_req` made while idle.
- R10: While `sel` is 0, every read strobe gets `rd_ack` on the next cycle. `rd_bit`=0 there means pull the line low.
- R11: While `sel` is 1, this layer ignores write and read strobes. It gives no `rd_ack` and `sel` stays high until `line_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_reset | input | 1 | Pulse: bus reset and presence completed |
| wr_stb | input | 1 | Pulse: master wrote one bit |
| wr_bit | input | 1 | Value of the written bit |
| rd_stb | input | 1 | Pulse: master opened a read slot |
| crc_req | input | 1 | Pulse: recheck the identity CRC |
| id_word | input | 64 | Identity: family [7:0], serial [55:8], CRC [63:56] |
| rd_ack | output | 1 | Read slot answered, one cycle after `rd_stb` |
| rd_bit | output | 1 | Bit for the slot; 0 drives the line low |
| sel | output | 1 | Device selected; memory layer owns the bus |
| crc_ok | output | 1 | One-cycle pulse: identity CRC correct |
| crc_bad | output | 1 | One-cycle pulse: identity CRC wrong |

## Verification
A wrong bit index or a skipped search phase shows up as a wrong `rd_bit` on the very slot concerned, one cycle after its strobe. A wrong command decode or a missed drop-out shows up later, as a `sel` level that differs from expectation once the command or address phase completes, or as a non-released read afterwards. CRC faults appear as the wrong pulse, or no pulse, about 65 cycles after the check starts. The bench drives random identities, random mismatch positions and random unknown codes, and compares every slot against values it computes itself.

// File: rtl/rom_layer_pkg.sv
package rom_layer_pkg;
  typedef enum logic [2:0] {
    ST_QUIET, ST_CMD, ST_READ, ST_MATCH,
    ST_SRCH_TRUE, ST_SRCH_CPL, ST_SRCH_DIR, ST_SEL
  } rom_st_t;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
endpackage

// File: rtl/rom_cmd_shift.sv
module rom_cmd_shift #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [CMD_W-1:0] word_next,
  output logic             is_last
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] word_q;
  logic [CNT_W-1:0] cnt_q;

  // bits arrive LSB first, so each new bit enters at the top
  assign word_next = {bit_in, word_q[CMD_W-1:1]};
  assign is_last   = (cnt_q == CNT_W'(CMD_W-1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (shift_en) begin
      word_q <= word_next;
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rom_crc_check.sv
module rom_crc_check #(
  parameter int              ID_W  = 64,
  parameter int              CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY_R = 8'h8C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [ID_W-1:0] id_word,
  output logic            ok,
  output logic            bad
);
  localparam int CNT_W = $clog2(ID_W);

  logic             pend_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q, crc_nx;
  logic             mix;

  // one reflected LFSR step per identity bit
  always_comb begin
    mix    = crc_q[0] ^ id_word[cnt_q];
    crc_nx = crc_q >> 1;
    if (mix) crc_nx = crc_nx ^ POLY_R;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= '0;
      ok     <= 1'b0;
      bad    <= 1'b0;
    end else begin
      ok  <= 1'b0;
      bad <= 1'b0;
      if (busy_q) begin
        crc_q <= crc_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ID_W-1)) begin
          busy_q <= 1'b0;
          ok     <= (crc_nx == '0);
          bad    <= (crc_nx != '0);
        end
      end else if (pend_q || req) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
        cnt_q  <= '0;
        crc_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/rom_seq.sv
module rom_seq
  import rom_layer_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_reset,
  input  logic             wr_stb,
  input  logic             wr_bit,
  input  logic             rd_stb,
  input  logic [ID_W-1:0]  id_word,
  input  logic [CMD_W-1:0] cmd_next,
  input  logic             cmd_last,
  output logic             in_cmd,
  output logic             rd_ack,
  output logic             rd_bit,
  output logic             sel
);
  localparam int IDX_W = $clog2(ID_W);

  rom_st_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             idx_end, own_bit;

  assign in_cmd  = (st_q == ST_CMD);
  assign sel     = (st_q == ST_SEL);
  assign idx_end = (idx_q == IDX_W'(ID_W-1));
  assign own_bit = id_word[idx_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_QUIET;
      idx_q  <= '0;
      rd_ack <= 1'b0;
      rd_bit <= 1'b1;
    end else begin
      rd_ack <= 1'b0;
      rd_bit <= 1'b1;
      if (line_reset) begin
        st_q  <= ST_CMD;
        idx_q <= '0;
      end else begin
        unique case (st_q)
          ST_CMD: begin
            if (wr_stb) begin
              if (cmd_last) begin
                unique case (cmd_next)
                  OP_READ:   st_q <= ST_READ;
                  OP_MATCH:  st_q <= ST_MATCH;
                  OP_SKIP:   st_q <= ST_SEL;
                  OP_SEARCH: st_q <= ST_SRCH_TRUE;
                  default:   st_q <= ST_QUIET;
                endcase
              end
            end else if (rd_stb) begin
              rd_ack <= 1'b1;
            end
          end
          ST_READ: begin
            if (rd_stb) begin
              rd_ack <= 1'b1;
              rd_bit <= own_bit;
              if (idx_end) st_q <= ST_SEL;
              else         idx_q <= idx_q + 1'b1;
            end
          end
          ST_MATCH: begin
            if (wr_stb) begin
              if (wr_bit != own_bit) st_q <= ST_QUIET;
              else if (idx_end)      st_q <= ST_SEL;
              else                   idx_q <= idx_q + 1'b1;
            end else if (rd_stb) begin
              rd_ack <= 1'b1;
            end
          end
          ST_SRCH_TRUE: begin
            if (rd_stb) begin
              rd_ack <= 1'b1;
              rd_bit <= own_bit;
              st_q   <= ST_SRCH_CPL;
            end
          end
          ST_SRCH_CPL: begin
            if (rd_stb) begin
              rd_ack <= 1'b1;
              rd_bit <= ~own_bit;
              st_q   <= ST_SRCH_DIR;
            end
          end
          ST_SRCH_DIR: begin
            if (wr_stb) begin
              if (wr_bit != own_bit) st_q <= ST_QUIET;
              else if (idx_end)      st_q <= ST_SEL;
              else begin
                idx_q <= idx_q + 1'b1;
                st_q  <= ST_SRCH_TRUE;
              end
            end else if (rd_stb) begin
              rd_ack <= 1'b1;
            end
          end
          ST_QUIET: begin
            if (rd_stb) rd_ack <= 1'b1;
          end
          ST_SEL: begin
            // memory layer owns the bit stream now
          end
          default: st_q <= ST_QUIET;
        endcase
      end
    end
  end
endmodule

// File: rtl/rom_select_layer.sv
module rom_select_layer #(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8,
  parameter int CRC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_reset,
  input  logic            wr_stb,
  input  logic            wr_bit,
  input  logic            rd_stb,
  input  logic            crc_req,
  input  logic [ID_W-1:0] id_word,
  output logic            rd_ack,
  output logic            rd_bit,
  output logic            sel,
  output logic            crc_ok,
  output logic            crc_bad
);
  logic [CMD_W-1:0] cmd_next;
  logic             cmd_last, in_cmd;

  rom_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .clear    (line_reset),
    .shift_en (wr_stb && in_cmd && !line_reset),
    .bit_in   (wr_bit),
    .word_next(cmd_next),
    .is_last  (cmd_last)
  );

  rom_seq #(.ID_W(ID_W), .CMD_W(CMD_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .line_reset(line_reset),
    .wr_stb    (wr_stb),
    .wr_bit    (wr_bit),
    .rd_stb    (rd_stb),
    .id_word   (id_word),
    .cmd_next  (cmd_next),
    .cmd_last  (cmd_last),
    .in_cmd    (in_cmd),
    .rd_ack    (rd_ack),
    .rd_bit    (rd_bit),
    .sel       (sel)
  );

  rom_crc_check #(.ID_W(ID_W), .CRC_W(CRC_W)) u_crc (
    .clk    (clk),
    .rst    (rst),
    .req    (crc_req),
    .id_word(id_word),
    .ok     (crc_ok),
    .bad    (crc_bad)
  );
endmodule

// File: rtl/rom_select_layer_chk.sv
module rom_select_layer_chk (
  input logic clk,
  input logic rst,
  input logic line_reset,
  input logic rd_stb,
  input logic rd_ack,
  input logic sel,
  input logic crc_ok,
  input logic crc_bad
);
  // R10: an unselected layer answers every read slot on the next cycle
  p_ack_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !sel && !line_reset) |=> rd_ack);

  // R10: no answer without a preceding request
  p_ack_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(rd_stb));

  // R11: selected layer stays silent on read slots
  p_no_ack_sel_r11: assert property (@(posedge clk) disable iff (rst)
    (sel && rd_stb && !line_reset) |=> !rd_ack);

  // R11: selection holds until a bus reset
  p_sel_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (sel && !line_reset) |=> sel);

  // R8: bus reset deselects
  p_sel_drop_r8: assert property (@(posedge clk) disable iff (rst)
    line_reset |=> !sel);

  // R9: result flags are exclusive single-cycle pulses
  p_crc_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(crc_ok && crc_bad));
  p_crc_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (crc_ok || crc_bad) |=> !(crc_ok || crc_bad));
endmodule

bind rom_select_layer rom_select_layer_chk u_chk (
  .clk(clk), .rst(rst), .line_reset(line_reset), .rd_stb(rd_stb),
  .rd_ack(rd_ack), .sel(sel), .crc_ok(crc_ok), .crc_bad(crc_bad)
);

// File: tb/rom_select_layer_tb.sv
module rom_select_layer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_reset = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0;
  logic        rd_stb = 1'b0, crc_req = 1'b0;
  logic [63:0] id_word;
  logic        rd_ack, rd_bit, sel, crc_ok, crc_bad;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rom_select_layer u_dut (
    .clk(clk), .rst(rst), .line_reset(line_reset), .wr_stb(wr_stb),
    .wr_bit(wr_bit), .rd_stb(rd_stb), .crc_req(crc_req), .id_word(id_word),
    .rd_ack(rd_ack), .rd_bit(rd_bit), .sel(sel), .crc_ok(crc_ok), .crc_bad(crc_bad)
  );

  function automatic logic [7:0] crc_of(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic m = c[0] ^ v[i];
      c = c >> 1;
      if (m) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [47:0] ser);
    logic [63:0] v = {8'h00, ser, 8'h02};
    v[63:56] = crc_of(v, 56);
    return v;
  endfunction

  task automatic chk(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_reset();
    @(negedge clk); line_reset = 1'b1;
    @(negedge clk); line_reset = 1'b0;
  endtask

  task automatic wr(input logic b);
    @(negedge clk); wr_bit = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(output logic a, output logic b);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    a = rd_ack; b = rd_bit;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wr(c[i]);
  endtask

  task automatic wait_crc(input logic want_ok, input string tag);
    logic seen_ok = 1'b0, seen_bad = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (crc_ok) seen_ok = 1'b1;
      if (crc_bad) seen_bad = 1'b1;
      if (crc_ok || crc_bad) break;
    end
    chk(seen_ok == want_ok && seen_bad == !want_ok, tag, {seen_ok, seen_bad}, {want_ok, !want_ok});
  endtask

  task automatic expect_quiet(input string tag);
    logic a, b;
    rd(a, b);
    chk(a == 1'b1 && b == 1'b1 && sel == 1'b0, tag, {sel, a, b}, 3'b011);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic a, b;
    logic [63:0] exp;
    void'($urandom(32'h5EED_0911));
    id_word = make_id(48'h0000_1234_5678);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk(sel == 1'b0 && rd_ack == 1'b0, "R1 reset outputs", {sel, rd_ack}, 2'b00);
    wait_crc(1'b1, "R9 power-up check of valid identity");
    expect_quiet("R1 quiet before first bus reset");

    // R3 skip, R11 ignore while selected
    pulse_reset();
    send_cmd(8'hCC);
    chk(sel == 1'b1, "R3 skip selects", sel, 1);
    rd(a, b);
    chk(a == 1'b0 && sel == 1'b1, "R11 no ack when selected", {sel, a}, 2'b10);
    wr(1'b0); wr(1'b1);
    chk(sel == 1'b1, "R11 writes ignored", sel, 1);

    // R8 reset clears selection
    pulse_reset();
    chk(sel == 1'b0, "R8 bus reset deselects", sel, 0);

    // R8 priority: reset together with a write
    @(negedge clk); line_reset = 1'b1; wr_stb = 1'b1; wr_bit = 1'b0;
    @(negedge clk); line_reset = 1'b0; wr_stb = 1'b0;
    send_cmd(8'hCC);
    chk(sel == 1'b1, "R8 write in reset cycle not counted", sel, 1);

    for (int it = 0; it < 4; it++) begin
      logic [47:0] ser = {16'($urandom), $urandom};
      int pos = $urandom_range(63, 0);
      logic [7:0] bad_op;
      id_word = make_id(ser);
      exp = id_word;

      // R4 read
      pulse_reset();
      send_cmd(8'h33);
      for (int i = 0; i < 64; i++) begin
        rd(a, b);
        chk(a == 1'b1 && b == exp[i], $sformatf("R4 read bit %0d", i), {a, b}, {1'b1, exp[i]});
      end
      chk(sel == 1'b1, "R4 selected after read", sel, 1);

      // R5 match equal
      pulse_reset();
      send_cmd(8'h55);
      for (int i = 0; i < 64; i++) wr(exp[i]);
      chk(sel == 1'b1, "R5 match selects", sel, 1);

      // R5 match mismatch at random position
      pulse_reset();
      send_cmd(8'h55);
      for (int i = 0; i < 64; i++) wr(i == pos ? ~exp[i] : exp[i]);
      chk(sel == 1'b0, $sformatf("R5 mismatch at %0d", pos), sel, 0);
      expect_quiet("R5 quiet after mismatch");

      // R6 full search
      pulse_reset();
      send_cmd(8'hF0);
      for (int i = 0; i < 64; i++) begin
        rd(a, b);
        chk(a && b == exp[i], "R6 search true bit", {a, b}, {1'b1, exp[i]});
        rd(a, b);
        chk(a && b == ~exp[i], "R6 search complement", {a, b}, {1'b1, ~exp[i]});
        wr(exp[i]);
      end
      chk(sel == 1'b1, "R6 search selects", sel, 1);

      // R7 search drop-out
      pulse_reset();
      send_cmd(8'hF0);
      for (int i = 0; i <= pos; i++) begin
        rd(a, b);
        rd(a, b);
        wr(i == pos ? ~exp[i] : exp[i]);
      end
      expect_quiet($sformatf("R7 dropped at %0d", pos));
      expect_quiet("R7 still quiet");

      // R2 unknown command
      do bad_op = 8'($urandom);
      while (bad_op == 8'h33 || bad_op == 8'h55 || bad_op == 8'hCC || bad_op == 8'hF0);
      pulse_reset();
      send_cmd(bad_op);
      expect_quiet($sformatf("R2 unknown code %0h", bad_op));
    end

    // R2 code bit order: 0x33 sent MSB first is 0xCC
    pulse_reset();
    for (int i = 7; i >= 0; i--) wr(8'h33 >> i);
    chk(sel == 1'b1, "R2 LSB-first decode", sel, 1);

    // R9 corrupted and restored CRC on request
    id_word = make_id(48'hABCD_EF01_2345) ^ 64'h0100_0000_0000_0000;
    @(negedge clk); crc_req = 1'b1;
    @(negedge clk); crc_req = 1'b0;
    wait_crc(1'b0, "R9 bad CRC flagged");
    id_word = make_id(48'hABCD_EF01_2345);
    @(negedge clk); crc_req = 1'b1;
    @(negedge clk); crc_req = 1'b0;
    wait_crc(1'b1, "R9 good CRC on request");

    finish_run();
  end
endmodule